// File: doc/BRIEF.md
# Receive FIFO with Selectable Error Status Presentation

This block is the buffering stage behind a serial receiver. Each character the deserializer hands over arrives as one push: a data byte and three error tags (parity error, framing error, received break). The character is stored in a 24-entry first-in first-out queue. The CPU side always sees the oldest character on its read-data output. A read strobe removes that character.

Status outputs tell software that data is waiting, that the queue is completely occupied, and that a character was lost because it arrived while the queue was full. The error tags are presented in one of two software-selected ways:

- **Per-character mode** shows the tags of the entry currently at the head.
- **Block mode** keeps a sticky OR of the tags of every entry that has reached the head since the last clear-error command. Software can then check a whole message once at its end.

A single interrupt line follows either the data-waiting indication or the queue-full indication, as selected by an input.

Top module: `rx_err_fifo`

## Requirements
- R1: During and after synchronous reset (rst_n low at a clock edge), the queue is empty: rx_ready=0, fifo_full=0, overrun=0, and stat_pe, stat_fe and stat_rb are all 0.
- R2: rx_ready is 1 exactly while at least one entry is stored.
- R3: cpu_data always presents the data byte of the oldest stored entry. A cycle with cpu_rd=1 removes that entry at the clock edge, so entries leave in arrival order. cpu_rd while the queue is empty has no effect.
- R4: fifo_full is 1 exactly while all 24 entries are occupied.
- R5: A push while 24 entries are stored is discarded, even if cpu_rd is high in the same cycle. It sets overrun from the next cycle on. overrun stays 1 until a cycle with clr_err=1 and no discarded push.
- R6: With blk_mode=0, stat_pe, stat_fe and stat_rb equal the tags of the head entry. They read 0 when the queue is empty.
- R7: With blk_mode=1, each stat flag is the OR of that tag over every entry that has been the head since the last clear-error command. The flag includes the current head in the same cycle that entry becomes the head, and it stays set after that entry is read.
- R8: clr_err=1 clears the block-mode accumulation at the clock edge. From the next cycle on, the flags restart from the current head's tags if an entry is stored, and read 0 otherwise.
- R9: irq equals rx_ready when irq_on_full=0 and equals fifo_full when irq_on_full=1.
- R10: With the queue neither empty nor full, a cycle with both rx_push and cpu_rd pops the head and appends the new entry, leaving the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_push | input | 1 | A received character is offered this cycle |
| rx_data | input | 8 | Data byte of the offered character |
| rx_pe | input | 1 | Parity-error tag of the offered character |
| rx_fe | input | 1 | Framing-error tag of the offered character |
| rx_rb | input | 1 | Received-break tag of the offered character |
| cpu_rd | input | 1 | Read strobe: remove the head entry |
| blk_mode | input | 1 | 0 = per-character status, 1 = block (accumulated) status |
| clr_err | input | 1 | Clear-error command: clears overrun and block accumulation |
| irq_on_full | input | 1 | Interrupt source: 0 = rx_ready, 1 = fifo_full |
| cpu_data | output | 8 | Data byte of the head entry |
| rx_ready | output | 1 | At least one entry stored |
| fifo_full | output | 1 | All entries occupied |
| overrun | output | 1 | Sticky: a character was discarded |
| stat_pe | output | 1 | Presented parity-error status |
| stat_fe | output | 1 | Presented framing-error status |
| stat_rb | output | 1 | Presented received-break status |
| irq | output | 1 | Selected interrupt request |

## Verification
The assertions watch several properties on every cycle:
- the occupancy never passes 24;
- a push into a full queue leaves the occupancy unchanged and raises overrun;
- overrun holds until a clear-error command;
- block-mode flags never drop without a clear-error command or a mode change;
- per-character flags read zero on an empty queue.

Only the bench scenarios can show the rest:
- that the data bytes leave in arrival order across a full wrap of the storage;
- that the accumulated flags take in exactly the entries that reached the head;
- that a clear-error command restarts the accumulation from the current head;
- that a push and a read in the same cycle both take effect.

// File: rtl/rxf_pkg.sv
// Package: shared types for the receive FIFO.
// Assumes an 8-bit character and three error tags per entry.
package rxf_pkg;
    localparam int RXF_DATA_W = 8;

    // Error tags carried with every stored character
    typedef struct packed {
        logic pe;
        logic fe;
        logic rb;
    } err_tags_t;

    // One queue entry: data byte plus its tags
    typedef struct packed {
        logic [RXF_DATA_W-1:0] data;
        err_tags_t             tags;
    } rx_entry_t;
endpackage

// File: rtl/rxf_store.sv
// Module: circular storage for received entries, with occupancy count and
// the sticky overrun flag. Assumes DEPTH >= 2. A push while full is dropped
// even when a read happens in the same cycle. Reset is synchronous, active low.
module rxf_store #(
    parameter int DEPTH = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  rxf_pkg::rx_entry_t  wr_entry,
    input  logic                rd_en,
    input  logic                clr_err,
    output rxf_pkg::rx_entry_t  head,
    output logic                empty,
    output logic                full,
    output logic                popped,
    output logic                overrun
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    rxf_pkg::rx_entry_t mem [DEPTH];
    logic [PTR_W-1:0]   wr_ptr;
    logic [PTR_W-1:0]   rd_ptr;
    logic [CNT_W-1:0]   count;
    logic               wr_ok;
    logic               rd_ok;
    logic               drop;

    // Next pointer position with wrap at a non-power-of-two depth
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    // Accept/pop qualification
    always_comb begin
        empty  = (count == '0);
        full   = (count == FULL_CNT);
        wr_ok  = wr_en && !full;
        rd_ok  = rd_en && !empty;
        drop   = wr_en && full;
        popped = rd_ok;
        head   = mem[rd_ptr];
    end

    // Entry storage write
    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wr_ptr] <= wr_entry;
        end
    end

    // Pointer and occupancy tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_ok) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (rd_ok) begin
                rd_ptr <= bump(rd_ptr);
            end
            case ({wr_ok, rd_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Sticky overrun: set by a dropped push, cleared by the clear-error command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (drop) begin
            overrun <= 1'b1;
        end else if (clr_err) begin
            overrun <= 1'b0;
        end
    end

    // R4: occupancy never exceeds the depth
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    // R5: a push into a full queue without a read leaves occupancy unchanged
    p_full_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> (count == $past(count)));

    // R5: a dropped push raises overrun
    p_overrun_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en) |=> overrun);

    // R5: overrun holds until a clear-error command
    p_overrun_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !clr_err) |=> overrun);
endmodule

// File: rtl/rxf_errview.sv
// Module: presents the error status, either the head entry's tags
// (per-character) or a sticky OR over every entry that has been the head since
// the last clear-error command (block). Assumes head_valid and the head tags
// come from the storage, and pop marks the cycle the head leaves.
module rxf_errview (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                blk_mode,
    input  logic                clr_err,
    input  logic                head_valid,
    input  rxf_pkg::err_tags_t  head_tags,
    input  logic                pop,
    output rxf_pkg::err_tags_t  stat
);
    rxf_pkg::err_tags_t acc;
    rxf_pkg::err_tags_t pend;
    logic               head_seen;

    // Tags of a head entry not yet folded into the accumulator
    always_comb begin
        pend = (head_valid && !head_seen) ? head_tags : '0;
    end

    // Block accumulator and the folded-in marker for the current head
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc       <= '0;
            head_seen <= 1'b0;
        end else if (clr_err) begin
            acc       <= '0;
            head_seen <= 1'b0;
        end else begin
            acc <= acc | pend;
            if (pop) begin
                head_seen <= 1'b0;
            end else if (head_valid) begin
                head_seen <= 1'b1;
            end
        end
    end

    // Output selection between per-character and block presentation
    always_comb begin
        if (blk_mode) begin
            stat = acc | pend;
        end else begin
            stat = head_valid ? head_tags : '0;
        end
    end

    // R6: per-character flags are zero on an empty queue
    p_char_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!blk_mode && !head_valid) |-> (stat == '0));

    // R7: block-mode parity flag never drops without clear or mode change
    p_blk_sticky_pe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_mode && !clr_err && stat.pe) |=> (!blk_mode || stat.pe));

    // R7: block-mode framing flag never drops without clear or mode change
    p_blk_sticky_fe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_mode && !clr_err && stat.fe) |=> (!blk_mode || stat.fe));

    // R7: block-mode break flag never drops without clear or mode change
    p_blk_sticky_rb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_mode && !clr_err && stat.rb) |=> (!blk_mode || stat.rb));
endmodule

// File: rtl/rx_err_fifo.sv
// Module: top of the receive FIFO. Joins the entry storage, the error-status
// presentation and the interrupt source selection. Assumes the deserializer
// delivers one complete character per rx_push pulse. Reset is synchronous,
// active low.
module rx_err_fifo #(
    parameter int DEPTH = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_push,
    input  logic [7:0] rx_data,
    input  logic       rx_pe,
    input  logic       rx_fe,
    input  logic       rx_rb,
    input  logic       cpu_rd,
    input  logic       blk_mode,
    input  logic       clr_err,
    input  logic       irq_on_full,
    output logic [7:0] cpu_data,
    output logic       rx_ready,
    output logic       fifo_full,
    output logic       overrun,
    output logic       stat_pe,
    output logic       stat_fe,
    output logic       stat_rb,
    output logic       irq
);
    rxf_pkg::rx_entry_t in_entry;
    rxf_pkg::rx_entry_t head;
    rxf_pkg::err_tags_t stat;
    logic               empty;
    logic               popped;

    // Pack the incoming character
    always_comb begin
        in_entry.data    = rx_data;
        in_entry.tags.pe = rx_pe;
        in_entry.tags.fe = rx_fe;
        in_entry.tags.rb = rx_rb;
    end

    rxf_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (rx_push),
        .wr_entry (in_entry),
        .rd_en    (cpu_rd),
        .clr_err  (clr_err),
        .head     (head),
        .empty    (empty),
        .full     (fifo_full),
        .popped   (popped),
        .overrun  (overrun)
    );

    rxf_errview u_view (
        .clk        (clk),
        .rst_n      (rst_n),
        .blk_mode   (blk_mode),
        .clr_err    (clr_err),
        .head_valid (!empty),
        .head_tags  (head.tags),
        .pop        (popped),
        .stat       (stat)
    );

    // Output mapping and interrupt source selection
    always_comb begin
        cpu_data = head.data;
        rx_ready = !empty;
        stat_pe  = stat.pe;
        stat_fe  = stat.fe;
        stat_rb  = stat.rb;
        irq      = irq_on_full ? fifo_full : rx_ready;
    end

    // R2: data waiting and queue full never contradict each other
    p_full_implies_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> rx_ready);
endmodule

// File: tb/tb_rx_err_fifo.sv
module tb_rx_err_fifo;
    localparam int DEPTH = 24;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       rx_push, rx_pe, rx_fe, rx_rb, cpu_rd, blk_mode, clr_err, irq_on_full;
    logic [7:0] rx_data;
    logic [7:0] cpu_data;
    logic       rx_ready, fifo_full, overrun, stat_pe, stat_fe, stat_rb, irq;

    int checks = 0;
    int failures = 0;
    logic [10:0] q[$];   // scoreboard: {data, pe, fe, rb}

    always #2.5 clk = ~clk;   // 200 MHz

    rx_err_fifo #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_data(rx_data),
        .rx_pe(rx_pe), .rx_fe(rx_fe), .rx_rb(rx_rb), .cpu_rd(cpu_rd),
        .blk_mode(blk_mode), .clr_err(clr_err), .irq_on_full(irq_on_full),
        .cpu_data(cpu_data), .rx_ready(rx_ready), .fifo_full(fifo_full),
        .overrun(overrun), .stat_pe(stat_pe), .stat_fe(stat_fe),
        .stat_rb(stat_rb), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Driver: offer one character and update the scoreboard
    task automatic push(input logic [7:0] d, input logic [2:0] t);
        rx_push = 1'b1; rx_data = d; {rx_pe, rx_fe, rx_rb} = t;
        tick();
        rx_push = 1'b0;
        if (q.size() < DEPTH) q.push_back({d, t});
    endtask

    // Monitor: compare the head with the scoreboard, then pop it
    task automatic pop(input string tag);
        logic [10:0] e;
        if (q.size() > 0) begin
            e = q.pop_front();
            chk({tag, " R3 data"}, cpu_data, e[10:3]);
        end
        cpu_rd = 1'b1;
        tick();
        cpu_rd = 1'b0;
    endtask

    task automatic stat_is(input string tag, input logic [2:0] exp);
        chk(tag, {stat_pe, stat_fe, stat_rb}, exp);
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 0; rx_push = 0; rx_data = 0; {rx_pe, rx_fe, rx_rb} = 0;
        cpu_rd = 0; blk_mode = 0; clr_err = 0; irq_on_full = 0;
        repeat (3) tick();
        chk("R1 ready in reset", rx_ready, 0);
        rst_n = 1;
        tick();
        chk("R1 ready", rx_ready, 0);
        chk("R1 full", fifo_full, 0);
        chk("R1 overrun", overrun, 0);
        stat_is("R1 flags", 3'b000);

        // Per-character mode: tags follow the head
        push(8'hA1, 3'b100);
        chk("R2 ready one entry", rx_ready, 1);
        stat_is("R6 head pe", 3'b100);
        push(8'hB2, 3'b010);
        push(8'hC3, 3'b001);
        stat_is("R6 head still first", 3'b100);
        pop("c0");
        stat_is("R6 head fe", 3'b010);
        pop("c1");
        stat_is("R6 head rb", 3'b001);
        pop("c2");
        chk("R2 ready empty", rx_ready, 0);
        stat_is("R6 empty zero", 3'b000);

        // Read on empty has no effect
        pop("empty");
        push(8'h5A, 3'b000);
        chk("R3 after empty read", cpu_data, 8'h5A);
        pop("c3");

        // Fill to full across pointer wrap, check interrupt selection
        for (int i = 0; i < DEPTH; i++) begin
            push(8'(8'h10 + i), 3'b000);
            if (i == DEPTH - 2) chk("R4 not full at 23", fifo_full, 0);
        end
        chk("R4 full", fifo_full, 1);
        chk("R9 irq ready src", irq, 1);
        irq_on_full = 1; #1;
        chk("R9 irq full src", irq, 1);
        push(8'hEE, 3'b111);
        chk("R5 overrun set", overrun, 1);
        chk("R5 still full", fifo_full, 1);
        // push with read while full: push dropped, read pops
        rx_push = 1; rx_data = 8'hDD; cpu_rd = 1;
        chk("R5 head before dual", cpu_data, 8'h10);
        tick();
        rx_push = 0; cpu_rd = 0;
        void'(q.pop_front());
        chk("R5 dual drop not full", fifo_full, 0);
        chk("R9 irq follows full", irq, 0);
        irq_on_full = 0; #1;
        chk("R9 irq follows ready", irq, 1);
        tick();
        chk("R5 overrun sticky", overrun, 1);
        while (q.size() > 0) pop("drain");
        chk("R3 drained order ready", rx_ready, 0);
        clr_err = 1; tick(); clr_err = 0;
        chk("R5 overrun cleared", overrun, 0);

        // Block mode accumulation
        blk_mode = 1;
        push(8'h61, 3'b100);
        stat_is("R7 first head", 3'b100);
        push(8'h62, 3'b010);
        push(8'h63, 3'b000);
        stat_is("R7 second not yet head", 3'b100);
        pop("b0");
        stat_is("R7 or of two", 3'b110);
        pop("b1");
        stat_is("R7 sticky", 3'b110);
        clr_err = 1; tick(); clr_err = 0;
        stat_is("R8 restart clean head", 3'b000);
        pop("b2");
        stat_is("R8 empty after clear", 3'b000);
        push(8'h64, 3'b001);
        stat_is("R7 new head rb", 3'b001);
        clr_err = 1; tick(); clr_err = 0;
        stat_is("R8 restart includes head", 3'b001);
        blk_mode = 0; #1;
        stat_is("R6 back to char", 3'b001);

        // Simultaneous push and read, neither empty nor full
        push(8'h65, 3'b000);
        rx_push = 1; rx_data = 8'h66; {rx_pe, rx_fe, rx_rb} = 3'b010; cpu_rd = 1;
        chk("R10 head before", cpu_data, 8'h64);
        tick();
        rx_push = 0; cpu_rd = 0;
        void'(q.pop_front());
        q.push_back({8'h66, 3'b010});
        chk("R10 new head", cpu_data, 8'h65);
        pop("d0");
        stat_is("R10 appended tags", 3'b010);
        pop("d1");
        chk("R10 empty", rx_ready, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule